// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Reads

This block is a 16-bit up-counter that runs for as long as the chip is out of reset. A fixed divide-by-four prescaler sits in front of it, so the count steps once every four bus clocks. Software reads the count over an 8-bit bus at two addresses, one for the upper byte and one for the lower byte. Read data is combinational, so it is valid in the same cycle as the read strobe.

Reading a 16-bit value in two 8-bit accesses can tear: the low byte may roll over between the two accesses. To prevent this, a read of the upper byte freezes a copy of the lower byte. The next read of the lower byte returns that frozen copy and then lets the lower-byte path follow the live counter again. Further upper-byte reads made while the copy is held leave the copy alone.

When the count wraps from all ones to zero, an overflow flag is set. The flag stays set until a clear input removes it. An interrupt request is raised while both the flag and an enable input are high.

Top module: `free_run_timer`

## Requirements
- R1: While reset is asserted and after its release, the count is 0xFFFC, the prescaler phase is zero, the overflow flag is low and no byte is held. The first lower-byte read after reset therefore returns the live byte.
- R2: After n rising clock edges since reset release, the count equals (0xFFFC + floor(n/4)) mod 65536. The sequence repeats every 262,144 clocks.
- R3: A read at address 0 returns the upper byte of the live count in the same cycle as the strobe.
- R4: A read at address 1 while no byte is held returns the lower byte of the live count.
- R5: A read at address 0 while no byte is held stores the lower byte of the count as it is in that cycle. Reads at address 1 then return the stored byte, including the read that releases it.
- R6: A read at address 0 while a byte is already held leaves the stored byte unchanged.
- R7: A read at address 1 releases the held byte. Later lower-byte reads follow the live count until the next upper-byte read.
- R8: On the clock edge at which the count goes from 0xFFFF to 0x0000, the overflow flag is set. This holds even if the clear input is high in that cycle.
- R9: With the clear input high and no wrap, the flag is low after the next edge. With clear low and no wrap, the flag holds its value.
- R10: The interrupt request is high exactly when the overflow flag is high and the enable input is high.
- R11: A read at address 2 or 3 returns zero and does not change the held byte or the hold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | 2 | Read address: 0 upper byte, 1 lower byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_ie | input | 1 | Interrupt enable for the overflow flag |
| rd_data | output | 8 | Read data, valid in the strobe cycle |
| ovf_flag | output | 1 | Overflow flag |
| irq | output | 1 | Overflow interrupt request |

## Verification
The assertions assume that a read strobe lasts one cycle per access and carries a single address, so an upper-byte and a lower-byte read never coincide. They also assume that the clear input is a plain level, sampled at the clock edge. The stimulus raises the strobe at a falling edge and drops it before the next access. It draws addresses from the full 2-bit range, including the unused codes. It pulses clear at arbitrary points, and once holds clear high across the first wrap so that the set-over-clear case is exercised.

// File: rtl/frt_pkg.sv
package frt_pkg;

    // bus and counter geometry
    parameter int unsigned BUS_W  = 8;
    localparam int unsigned CNT_W = 2 * BUS_W;
    parameter int unsigned PRE_W  = 2;
    parameter int unsigned ADDR_W = 2;

    // register decode
    parameter logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(0);
    parameter logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(1);

    // preset value: all ones with the two lowest bits clear
    localparam logic [CNT_W-1:0] CNT_INIT = {{(CNT_W-2){1'b1}}, 2'b00};

    typedef logic [BUS_W-1:0] byte_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [PRE_W-1:0] phase;
    } pre_st_t;

    typedef struct packed {
        cnt_t value;
    } cnt_st_t;

    typedef struct packed {
        logic armed;
        byte_t held;
    } latch_st_t;

    typedef struct packed {
        logic flag;
    } flag_st_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_HI   = 2'd1,
        SEL_LO   = 2'd2
    } sel_e;

endpackage

// File: rtl/frt_prescale.sv
module frt_prescale
    import frt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);

    pre_st_t st_q, st_d;

    localparam logic [PRE_W-1:0] LAST_PHASE = '1;

    always_comb begin
        st_d = st_q;
        st_d.phase = st_q.phase + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = (st_q.phase == LAST_PHASE);

endmodule

// File: rtl/frt_counter.sv
module frt_counter
    import frt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    output cnt_t cnt_o,
    output logic wrap_o
);

    cnt_st_t st_q, st_d;

    localparam cnt_t CNT_TOP = '1;

    always_comb begin
        st_d = st_q;
        if (tick_i) begin
            st_d.value = st_q.value + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.value <= CNT_INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o  = st_q.value;
    assign wrap_o = tick_i && (st_q.value == CNT_TOP);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(st_q.value));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (st_q.value == CNT_W'($past(st_q.value) + 1'b1)));

endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag
    import frt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);

    flag_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (wrap_i) begin
            st_d.flag = 1'b1;
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
    assign irq_o  = st_q.flag & ie_i;

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> st_q.flag);

    // R9
    ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_i && clr_i) |=> !st_q.flag);

    // R9
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap_i && !clr_i) |=> $stable(st_q.flag));

endmodule

// File: rtl/frt_byte_latch.sv
module frt_byte_latch
    import frt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  byte_t live_lo_i,
    input  logic  hi_rd_i,
    input  logic  lo_rd_i,
    output byte_t lo_byte_o
);

    latch_st_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (hi_rd_i && !st_q.armed) begin
            st_d.armed = 1'b1;
            st_d.held  = live_lo_i;
        end else if (lo_rd_i) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_byte_o = st_q.armed ? st_q.held : live_lo_i;

    // R5
    cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd_i && !st_q.armed) |=> (st_q.armed && st_q.held == $past(live_lo_i)));

    // R6
    no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd_i && st_q.armed) |=> $stable(st_q.held));

    // R7
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_rd_i && !hi_rd_i) |=> !st_q.armed);

    // R11
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_rd_i && !lo_rd_i) |=> ($stable(st_q.armed) && $stable(st_q.held)));

endmodule

// File: rtl/free_run_timer.sv
module free_run_timer
    import frt_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            rd_en,
    input  logic [frt_pkg::ADDR_W-1:0]      rd_addr,
    input  logic                            ovf_clr,
    input  logic                            ovf_ie,
    output logic [frt_pkg::BUS_W-1:0]       rd_data,
    output logic                            ovf_flag,
    output logic                            irq
);

    logic  tick;
    logic  wrap;
    cnt_t  cnt;
    byte_t lo_byte;
    sel_e  sel;

    always_comb begin
        sel = SEL_NONE;
        if (rd_en) begin
            if (rd_addr == HI_ADDR) begin
                sel = SEL_HI;
            end else if (rd_addr == LO_ADDR) begin
                sel = SEL_LO;
            end
        end
    end

    frt_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    frt_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    frt_ovf_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .wrap_i (wrap),
        .clr_i  (ovf_clr),
        .ie_i   (ovf_ie),
        .flag_o (ovf_flag),
        .irq_o  (irq)
    );

    frt_byte_latch u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .live_lo_i (cnt[BUS_W-1:0]),
        .hi_rd_i   (sel == SEL_HI),
        .lo_rd_i   (sel == SEL_LO),
        .lo_byte_o (lo_byte)
    );

    always_comb begin
        unique case (sel)
            SEL_HI:  rd_data = cnt[CNT_W-1:BUS_W];
            SEL_LO:  rd_data = lo_byte;
            default: rd_data = '0;
        endcase
    end

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (cnt == '0));

    // R10
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag && ovf_ie));

endmodule

// File: tb/test_free_run_timer.sv
module test_free_run_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] rd_addr = 2'd0;
    logic       ovf_clr = 1'b0;
    logic       ovf_ie = 1'b0;
    logic [7:0] rd_data;
    logic       ovf_flag;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference state
    int   edges = 0;
    logic m_tof = 1'b0;
    logic m_armed = 1'b0;
    logic [7:0] m_held = 8'h00;

    always #10 clk = ~clk;

    free_run_timer i_free_run_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .ovf_clr  (ovf_clr),
        .ovf_ie   (ovf_ie),
        .rd_data  (rd_data),
        .ovf_flag (ovf_flag),
        .irq      (irq)
    );

    function automatic logic [15:0] exp_cnt(input int e);
        return 16'hFFFC + 16'(e / 4);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edges <= 0;
            m_tof <= 1'b0;
        end else begin
            edges <= edges + 1;
            if ((edges % 4 == 3) && exp_cnt(edges) == 16'hFFFF) m_tof <= 1'b1;
            else if (ovf_clr) m_tof <= 1'b0;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_flags(input string req);
        chk(req, {31'd0, ovf_flag}, {31'd0, m_tof});
        chk("R10", {31'd0, irq}, {31'd0, m_tof & ovf_ie});
    endtask

    task automatic do_read(input logic [1:0] a);
        logic [15:0] c;
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        #2;
        c = exp_cnt(edges);
        if (a == 2'd0) begin
            chk("R3", {24'd0, rd_data}, {24'd0, c[15:8]});
            if (!m_armed) begin
                m_armed = 1'b1;
                m_held = c[7:0];
            end
        end else if (a == 2'd1) begin
            if (m_armed) chk("R5", {24'd0, rd_data}, {24'd0, m_held});
            else chk("R4", {24'd0, rd_data}, {24'd0, c[7:0]});
            m_armed = 1'b0;
        end else begin
            chk("R11", {24'd0, rd_data}, 32'd0);
        end
        chk_flags("R9");
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] c;
        void'($urandom(32'd4711));
        // R1: reset state, read during reset
        ovf_clr = 1'b1;
        repeat (3) @(negedge clk);
        rd_en = 1'b1; rd_addr = 2'd1; #2;
        chk("R1", {24'd0, rd_data}, 32'hFC);
        rd_addr = 2'd0; #2;
        chk("R1", {24'd0, rd_data}, 32'hFF);
        chk("R1", {31'd0, ovf_flag}, 32'd0);
        rd_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        // R8: clear held high across the first wrap, set must win
        repeat (15) @(negedge clk);
        chk("R9", {31'd0, ovf_flag}, 32'd0);
        @(negedge clk);
        chk("R8", {31'd0, ovf_flag}, 32'd1);
        ovf_clr = 1'b0;
        // R1: first low read after reset is transparent
        do_read(2'd1);
        // R10: enable gating
        ovf_ie = 1'b1; #1;
        chk("R10", {31'd0, irq}, 32'd1);
        // R9: clear pulse
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk("R9", {31'd0, ovf_flag}, 32'd0);
        chk("R10", {31'd0, irq}, 32'd0);
        // R5 R6 R7: directed coherent sequence
        do_read(2'd0);
        repeat (7) @(negedge clk);
        do_read(2'd0);
        repeat (5) @(negedge clk);
        do_read(2'd2);
        do_read(2'd1);
        do_read(2'd1);
        // random mix
        for (int i = 0; i < 400; i++) begin
            case ($urandom % 7)
                0, 1: do_read(2'd0);
                2, 3: do_read(2'd1);
                4: do_read(2'($urandom % 2) + 2'd2);
                5: repeat ($urandom % 9) @(negedge clk);
                default: begin
                    @(negedge clk);
                    ovf_ie = 1'($urandom);
                    ovf_clr = 1'($urandom);
                    @(negedge clk);
                    ovf_clr = 1'b0;
                end
            endcase
        end
        // R2: long run, then coherent read of the full count
        if (m_armed) do_read(2'd1);
        repeat (20000) @(negedge clk);
        @(negedge clk);
        #2;
        c = exp_cnt(edges);
        rd_en = 1'b1; rd_addr = 2'd0; #1;
        chk("R2", {24'd0, rd_data}, {24'd0, c[15:8]});
        rd_addr = 2'd1; #1;
        chk("R2", {24'd0, rd_data}, {24'd0, c[7:0]});
        rd_en = 1'b0;
        chk_flags("R8");
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule